// File: doc/BRIEF.md
# 24-Hour BCD Time-of-Day Counter

This block keeps the time of day as six binary-coded-decimal digits in hours, minutes and seconds order. It advances by one second on each clock cycle in which the once-per-second tick enable is high. Seconds and minutes are each a modulo-60 stage. Each stage is a units decade counter feeding a tens counter that runs modulo six. The hour stage is a decade units digit paired with a small tens digit. An extra decode clears both hour digits when 23 is passed, so the hour display wraps to 00.

Each digit also drives a seven-segment pattern output. The patterns come from the registered digits, so digits and patterns change on the same clock edge. When the count rolls from 23:59:59 to 00:00:00, the block raises a one-cycle day-carry pulse so that a date counter can be chained behind it. Time setting and alarms are not part of this block.

Top module: `tod_bcd_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, all six digits become 0 and `dayCarry` becomes 0 at that edge, whatever `tickEn` is.
- R2: When `tickEn` is low at an edge (and `rst` is low), every digit keeps its value and `dayCarry` is 0 after the edge.
- R3: The seconds units digit rises by one on every tick. It goes from 9 back to 0, and on that same tick the seconds tens digit advances.
- R4: The seconds tens digit counts 0 through 5. At :59 a tick clears both seconds digits and advances the minutes units digit.
- R5: The minutes units and tens digits behave as a modulo-60 stage in the same way as the seconds. At 59:59 a tick clears the minutes and advances the hour units digit.
- R6: While the hour tens digit is 0 or 1, the hour units digit counts 0 to 9, and 09:59:59 and 19:59:59 roll to 10:00:00 and 20:00:00.
- R7: While the hour tens digit is 2, the hour units digit counts only 0 to 3. A tick at 23:59:59 gives 00:00:00, and the hour tens digit never exceeds 2.
- R8: `dayCarry` is high for exactly the one cycle that follows the edge at which 23:59:59 became 00:00:00, and is low at all other times.
- R9: Each 7-bit segment field is active high, with bit 0 = segment a through bit 6 = segment g. Digits 0..9 map to hex 3F,06,5B,4F,66,6D,7D,07,7F,6F. Field k of `segOut` (bits 7k+6..7k) shows digit k of `bcdDigits`.
- R10: `bcdDigits` packs the digits in this order: bits 23:20 hour tens, 19:16 hour units, 15:12 minute tens, 11:8 minute units, 7:4 second tens, 3:0 second units.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-second advance enable |
| bcdDigits | output | 24 | Six BCD digits, HH:MM:SS packing per R10 |
| segOut | output | 42 | Six seven-segment patterns, one per digit |
| dayCarry | output | 1 | One-cycle midnight rollover pulse |

## Verification
The hardest state to reach from the ports is the final tick of the day, 23:59:59. Only there do the forced hour clear, the full carry ripple and the day-carry pulse all act at once. No state can be loaded into the block, so the stimulus first runs an irregular tick pattern with a reset in the middle. It then holds the tick high for more than 86,400 cycles, so the count crosses midnight once. The reference model is compared after every edge of that run. As a result, the 09→10 and 19→20 hour carries, each minute and second rollover, and the exact cycle of the carry pulse are all compared against independently computed time.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_DIGITS = 6;
  localparam int DIGIT_W    = 4;
  localparam int SEG_W      = 7;

  typedef struct packed {
    logic [NUM_DIGITS-1:0] inc;
    logic [NUM_DIGITS-1:0] clr;
    logic                  dayWrap;
  } todStrobe_t;
endpackage

// File: rtl/seg7_decode.sv
module seg7_decode
  import tod_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  output logic [SEG_W-1:0]   seg
);
  // active-high, bit0 = a ... bit6 = g
  always_comb begin
    unique case (digit)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/tod_control.sv
module tod_control
  import tod_pkg::*;
#(
  parameter int UNITS_LAST    = 9,
  parameter int TENS_LAST     = 5,
  parameter int HR_TENS_LAST  = 2,
  parameter int HR_UNITS_WRAP = 3
) (
  input  logic                                tickEn,
  input  logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  digits,
  output todStrobe_t                          strobe
);
  localparam int HR_U = NUM_DIGITS - 2;
  localparam int HR_T = NUM_DIGITS - 1;

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] lastVal;
  logic [NUM_DIGITS-1:0]              atLast;
  logic [NUM_DIGITS-1:0]              enable;

  // terminal value of each digit; hour units shortens when tens is at its top
  always_comb begin
    for (int i = 0; i < NUM_DIGITS - 2; i++) begin
      lastVal[i] = (i % 2 == 0) ? DIGIT_W'(UNITS_LAST) : DIGIT_W'(TENS_LAST);
    end
    lastVal[HR_U] = (digits[HR_T] == DIGIT_W'(HR_TENS_LAST)) ?
                    DIGIT_W'(HR_UNITS_WRAP) : DIGIT_W'(UNITS_LAST);
    lastVal[HR_T] = DIGIT_W'(HR_TENS_LAST);
  end

  assign enable[0] = tickEn;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
    assign atLast[i] = (digits[i] == lastVal[i]);
    if (i > 0) begin : g_ripple
      assign enable[i] = enable[i-1] & atLast[i-1];
    end
    assign strobe.inc[i] = enable[i] & ~atLast[i];
    assign strobe.clr[i] = enable[i] &  atLast[i];
  end

  assign strobe.dayWrap = enable[HR_T] & atLast[HR_T];
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst,
  input  todStrobe_t                          strobe,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0]  digits,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0]    segs,
  output logic                                dayCarry
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst)                digits[i] <= '0;
      else if (strobe.clr[i]) digits[i] <= '0;
      else if (strobe.inc[i]) digits[i] <= digits[i] + DIGIT_W'(1);
    end

    seg7_decode u_seg (
      .digit (digits[i]),
      .seg   (segs[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dayCarry <= 1'b0;
    else     dayCarry <= strobe.dayWrap;
  end
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
  import tod_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tickEn,
  output logic [NUM_DIGITS*DIGIT_W-1:0] bcdDigits,
  output logic [NUM_DIGITS*SEG_W-1:0]   segOut,
  output logic                          dayCarry
);
  todStrobe_t                         strobe;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;
  logic [NUM_DIGITS-1:0][SEG_W-1:0]   segs;

  tod_control u_ctrl (
    .tickEn (tickEn),
    .digits (digits),
    .strobe (strobe)
  );

  tod_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .digits   (digits),
    .segs     (segs),
    .dayCarry (dayCarry)
  );

  assign bcdDigits = digits;
  assign segOut    = segs;
endmodule

// File: rtl/tod_checker.sv
module tod_checker (
  input logic        clk,
  input logic        rst,
  input logic        tickEn,
  input logic [23:0] bcdDigits,
  input logic        dayCarry
);
  logic [3:0] sU, sT, mU, mT, hU, hT;
  assign {hT, hU, mT, mU, sT, sU} = bcdDigits;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (bcdDigits == 24'h0 && !dayCarry));

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> ($stable(bcdDigits) && !dayCarry));

  assert_sec_units_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tickEn && sU != 4'd9) |=> (sU == $past(sU) + 4'd1));

  assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
    (sU <= 4'd9 && sT <= 4'd5));

  assert_min_range_R5: assert property (@(posedge clk) disable iff (rst)
    (mU <= 4'd9 && mT <= 4'd5));

  assert_hour_range_R7: assert property (@(posedge clk) disable iff (rst)
    (hT <= 4'd2 && (hT != 4'd2 || hU <= 4'd3) && hU <= 4'd9));

  assert_midnight_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (tickEn && bcdDigits == 24'h235959) |=> (bcdDigits == 24'h0 && dayCarry));

  assert_carry_single_R8: assert property (@(posedge clk) disable iff (rst)
    dayCarry |=> !dayCarry);

  assert_carry_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    dayCarry |-> bcdDigits == 24'h0);
endmodule

bind tod_bcd_counter tod_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tickEn    (tickEn),
  .bcdDigits (bcdDigits),
  .dayCarry  (dayCarry)
);

// File: tb/sim_tod_bcd_counter.sv
`timescale 1ns/1ps
module sim_tod_bcd_counter;
  localparam int HALF = 10;          // 50 MHz
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic [23:0] bcdDigits;
  logic [41:0] segOut;
  logic        dayCarry;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state: seconds since midnight
  int refT = 0;
  bit refCarry = 1'b0;
  bit lastRst = 1'b1;
  bit lastTick = 1'b0;
  bit started = 1'b0;

  always #HALF clk = ~clk;

  tod_bcd_counter u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .bcdDigits(bcdDigits), .segOut(segOut), .dayCarry(dayCarry)
  );

  function automatic logic [6:0] segRef(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic checkVal(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (ref time %0d)", tag, what, got, exp, refT);
    end
  endtask

  // reference update at each edge
  always @(posedge clk) begin
    started  <= 1'b1;
    lastRst  <= rst;
    lastTick <= tickEn;
    if (rst) begin
      refT = 0; refCarry = 1'b0;
    end else if (tickEn) begin
      refCarry = (refT == 86399);
      refT = (refT + 1) % 86400;
    end else begin
      refCarry = 1'b0;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      int h, m, s;
      int expD[6];
      string tags[6];
      h = refT / 3600; m = (refT / 60) % 60; s = refT % 60;
      expD[0] = s % 10; expD[1] = s / 10; expD[2] = m % 10;
      expD[3] = m / 10; expD[4] = h % 10; expD[5] = h / 10;
      tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5";
      tags[3] = "R5"; tags[4] = "R6"; tags[5] = "R7";
      for (int k = 0; k < 6; k++) begin
        string tg;
        tg = lastRst ? "R1" : (!lastTick ? "R2" : tags[k]);
        checkVal(tg, $sformatf("digit%0d", k), int'(bcdDigits[4*k +: 4]), expD[k]);
        checkVal("R9", $sformatf("seg%0d", k), int'(segOut[7*k +: 7]), int'(segRef(expD[k])));
      end
      checkVal("R10", "packed HHMMSS",
               int'(bcdDigits), (expD[5] << 20) | (expD[4] << 16) | (expD[3] << 12) |
                                (expD[2] << 8) | (expD[1] << 4) | expD[0]);
      checkVal(lastRst ? "R1" : "R8", "dayCarry", int'(dayCarry), int'(refCarry));
    end
  end

  task automatic cycles(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: tickEn = 1'b0;
        1: tickEn = 1'b1;
        default: tickEn = (i % 3 != 0) && (i % 7 != 5);
      endcase
    end
  endtask

  initial begin
    rst = 1'b1; tickEn = 1'b1;               // R1: reset wins over tick
    cycles(3, 1);
    @(negedge clk); rst = 1'b0; tickEn = 1'b0;
    cycles(5, 0);                            // R2: holds at zero
    cycles(400, 2);                          // irregular ticks
    @(negedge clk); rst = 1'b1;              // R1: mid-count reset
    @(negedge clk); rst = 1'b0;
    cycles(150, 2);
    cycles(10, 0);                           // R2: hold mid-count
    cycles(86600, 1);                        // full day: R3..R8
    cycles(10, 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule